// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It runs off a receive-clock enable. The enable is divided by 1, 16 or 64 to give the bit period. A falling edge on the idle-high line is taken as a start bit. In the two oversampled ratios, that start bit must still be low at its half-bit point. After that, every later bit is sampled at its middle. The word-select setting gives the frame shape: 7 or 8 data bits, optional odd or even parity, and one or two stop bits. Only the first stop bit is checked.

Each finished character moves into a holding register together with its framing-error and parity-error flags. The flags stay attached to that character until a newer character replaces it. A data-read acknowledge empties the register. If a second character completes while the register is still full, the overrun flag is set. The older character and its flags are kept, and the receiver stays in step with the line. While the carrier-lost input is high, the full indication reads as empty.

Top module: `serial_rx_deser`

## Requirements
- R1: After reset, `rx_full`, `overrun`, `frame_err` and `parity_err` are 0, `rx_data` is 0x00, and the line is treated as idle.
- R2: `word_sel` selects the frame, as follows.
  - `word_sel[2]`=0 gives 7 data bits with parity; `word_sel[0]`=1 selects odd parity and 0 selects even.
  - `word_sel` 3'b100 and 3'b101 give 8 data bits with no parity.
  - `word_sel` 3'b110 gives 8 data bits with even parity; 3'b111 gives 8 data bits with odd parity.
  - The first data bit after the start bit lands in `rx_data[0]`.
- R3: In the 7-bit modes, `rx_data[7]` reads 0.
- R4: `div_sel` 2'b00 sets one `rx_tick` per bit, 2'b01 sets 16 and 2'b1x sets 64. Characters at each of these bit periods are received correctly.
- R5: At ratios 16 and 64, a low pulse that has ended before the half-bit point is discarded, and no character is produced.
- R6: `parity_err` is 1 when the data bits plus the parity bit hold an odd number of ones and even parity is selected, or an even number of ones and odd parity is selected.
- R7: In the no-parity modes, `parity_err` is 0 for every character.
- R8: `frame_err` is 1 when the first stop bit samples low, and 0 when it samples high.
- R9: A cycle with `rd_ack` high and no character completing clears `rx_full` and `overrun` on the next clock.
- R10: A character that completes while the register is full sets `overrun`. The held data and flags do not change, and `rx_full` stays 1.
- R11: While `carrier_lost` is 1, `rx_full` reads 0. The held character is unaffected and shows again when `carrier_lost` returns to 0.
- R12: After an overrun and a read, the next character on the line is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_tick | input | 1 | Receive-clock enable, one clk cycle wide |
| rx_line | input | 1 | Serial input, idle high |
| div_sel | input | 2 | Ticks per bit: 00=1, 01=16, 1x=64 |
| word_sel | input | 3 | Frame shape (see R2) |
| carrier_lost | input | 1 | Carrier absent; masks `rx_full` |
| rd_ack | input | 1 | Held character consumed |
| rx_data | output | 8 | Held character |
| rx_full | output | 1 | Holding register has an unread character |
| frame_err | output | 1 | Held character had a low first stop bit |
| parity_err | output | 1 | Held character failed its parity check |
| overrun | output | 1 | A character was lost while the register was full |

## Verification
The bound checker covers the holding-register rules on every cycle. A read must clear the full and overrun state. Overrun may only rise over a full register. The held data must not move while the register is full and unread. A newly loaded character must have a zero top bit in the 7-bit modes and no parity error in the no-parity modes. Line-level behaviour can only be shown by the bench's frame scenarios. That covers bit order, each divide ratio, the half-bit start check, parity and framing detection, carrier masking, and reception continuing after an overrun.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_START,
      PH_BITS
   } rx_phase_e;

   typedef struct packed {
      logic [7:0] data;
      logic       frame_err;
      logic       parity_err;
   } rx_char_t;

   // parity present in all 7-bit modes and in the two upper 8-bit modes
   function automatic logic parity_on(input logic [2:0] ws);
      return !ws[2] || ws[1];
   endfunction

   // samples taken after the start bit: data + parity + first stop
   function automatic logic [3:0] frame_len(input logic [2:0] ws);
      return (ws[2] ? 4'd8 : 4'd7) + {3'd0, parity_on(ws)} + 4'd1;
   endfunction

endpackage

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
   import serial_rx_pkg::*;
#(
   parameter int DIV_MID     = 16,
   parameter int DIV_HIGH    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_tick,
   input  logic       rx_line,
   input  logic [1:0] div_sel,
   input  logic [2:0] word_sel,
   output logic       samp_stb,
   output logic       samp_bit,
   output logic [3:0] samp_idx,
   output logic       samp_last
);
   localparam int CNT_W = $clog2(DIV_HIGH) + 1;

   logic             rx_s;
   logic [CNT_W-1:0] div_now, half, cnt;
   logic [3:0]       idx, last_idx;
   rx_phase_e        phase;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign rx_s = rx_line;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n) sr <= '1;
            else begin
               sr[0] <= rx_line;
               for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign rx_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   always_comb begin
      case (div_sel)
         2'b00:   div_now = CNT_W'(1);
         2'b01:   div_now = CNT_W'(DIV_MID);
         default: div_now = CNT_W'(DIV_HIGH);
      endcase
      half     = div_now >> 1;
      last_idx = frame_len(word_sel) - 4'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         idx       <= '0;
         samp_stb  <= 1'b0;
         samp_bit  <= 1'b1;
         samp_idx  <= '0;
         samp_last <= 1'b0;
      end else begin
         samp_stb <= 1'b0;
         if (rx_tick) begin
            case (phase)
               PH_IDLE: if (!rx_s) begin
                  cnt   <= CNT_W'(1);
                  idx   <= '0;
                  phase <= (div_now == CNT_W'(1)) ? PH_BITS : PH_START;
               end
               PH_START: begin
                  if (cnt == half) begin
                     cnt   <= CNT_W'(1);
                     phase <= rx_s ? PH_IDLE : PH_BITS;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               PH_BITS: begin
                  if (cnt == div_now) begin
                     cnt       <= CNT_W'(1);
                     samp_stb  <= 1'b1;
                     samp_bit  <= rx_s;
                     samp_idx  <= idx;
                     samp_last <= (idx == last_idx);
                     if (idx == last_idx) phase <= PH_IDLE;
                     else                 idx   <= idx + 4'd1;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/rx_char_builder.sv
module rx_char_builder
   import serial_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       samp_stb,
   input  logic       samp_bit,
   input  logic [3:0] samp_idx,
   input  logic       samp_last,
   input  logic [2:0] word_sel,
   output logic       xfer,
   output rx_char_t   char_o
);
   logic [8:0] sbuf;
   logic [7:0] data_v;
   logic       par_bit;
   rx_char_t   next_char;

   always_comb begin
      data_v  = word_sel[2] ? sbuf[7:0] : {1'b0, sbuf[6:0]};
      par_bit = word_sel[2] ? sbuf[8] : sbuf[7];
      next_char.data       = data_v;
      next_char.frame_err  = !samp_bit;
      next_char.parity_err = parity_on(word_sel) && ((^data_v ^ par_bit) != word_sel[0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sbuf   <= '0;
         xfer   <= 1'b0;
         char_o <= '0;
      end else begin
         xfer <= 1'b0;
         if (samp_stb) begin
            if (!samp_last) begin
               sbuf[samp_idx] <= samp_bit;
            end else begin
               xfer   <= 1'b1;
               char_o <= next_char;
            end
         end
      end
   end
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
   import serial_rx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     xfer,
   input  rx_char_t char_in,
   input  logic     rd_ack,
   output rx_char_t held,
   output logic     full,
   output logic     overrun
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held    <= '0;
         full    <= 1'b0;
         overrun <= 1'b0;
      end else if (xfer && (!full || rd_ack)) begin
         held    <= char_in;
         full    <= 1'b1;
         overrun <= 1'b0;
      end else if (xfer) begin
         overrun <= 1'b1;
      end else if (rd_ack) begin
         full    <= 1'b0;
         overrun <= 1'b0;
      end
   end
endmodule

// File: rtl/serial_rx_deser.sv
module serial_rx_deser
   import serial_rx_pkg::*;
#(
   parameter int DIV_MID     = 16,
   parameter int DIV_HIGH    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_tick,
   input  logic       rx_line,
   input  logic [1:0] div_sel,
   input  logic [2:0] word_sel,
   input  logic       carrier_lost,
   input  logic       rd_ack,
   output logic [7:0] rx_data,
   output logic       rx_full,
   output logic       frame_err,
   output logic       parity_err,
   output logic       overrun
);
   initial begin
      assert (DIV_MID >= 2 && (DIV_MID & (DIV_MID - 1)) == 0)
         else $error("DIV_MID must be a power of two, at least 2");
      assert (DIV_HIGH > DIV_MID && (DIV_HIGH & (DIV_HIGH - 1)) == 0)
         else $error("DIV_HIGH must be a power of two above DIV_MID");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("SYNC_STAGES must be 0..4");
   end

   logic       samp_stb, samp_bit, samp_last;
   logic [3:0] samp_idx;
   logic       xfer_w;
   rx_char_t   built, held;
   logic       held_full;

   rx_bit_timer #(
      .DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH), .SYNC_STAGES(SYNC_STAGES)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
      .div_sel(div_sel), .word_sel(word_sel),
      .samp_stb(samp_stb), .samp_bit(samp_bit), .samp_idx(samp_idx),
      .samp_last(samp_last)
   );

   rx_char_builder u_build (
      .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .samp_bit(samp_bit),
      .samp_idx(samp_idx), .samp_last(samp_last), .word_sel(word_sel),
      .xfer(xfer_w), .char_o(built)
   );

   rx_hold_reg u_hold (
      .clk(clk), .rst_n(rst_n), .xfer(xfer_w), .char_in(built),
      .rd_ack(rd_ack), .held(held), .full(held_full), .overrun(overrun)
   );

   assign rx_data    = held.data;
   assign frame_err  = held.frame_err;
   assign parity_err = held.parity_err;
   assign rx_full    = held_full && !carrier_lost;
endmodule

// File: rtl/serial_rx_deser_chk.sv
module serial_rx_deser_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_ack,
   input logic [2:0] word_sel,
   input logic       xfer,
   input logic       held_full,
   input logic       overrun,
   input logic [7:0] rx_data,
   input logic       parity_err
);
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack && !xfer |=> !held_full && !overrun); // R9
   AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(held_full)); // R10
   AST_OVR_IMPLIES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> held_full); // R10
   AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      held_full && !rd_ack |=> $stable(rx_data)); // R10
   AST_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      xfer && !word_sel[2] && (!held_full || rd_ack) |=> !rx_data[7]); // R3
   AST_NOPAR_NO_PE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer && word_sel[2] && !word_sel[1] && (!held_full || rd_ack) |=> !parity_err); // R7
endmodule

bind serial_rx_deser serial_rx_deser_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rd_ack(rd_ack), .word_sel(word_sel),
   .xfer(xfer_w), .held_full(held_full), .overrun(overrun),
   .rx_data(rx_data), .parity_err(parity_err)
);

// File: tb/tb_serial_rx_deser.sv
module tb_serial_rx_deser;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] tcnt = 2'd0;
   logic       rx = 1'b1;
   logic [1:0] div_sel = 2'b01;
   logic [2:0] word_sel = 3'b101;
   logic       carrier_lost = 1'b0;
   logic       rd_ack = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, frame_err, parity_err, overrun;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   always #5 clk = ~clk;

   always_ff @(posedge clk) begin
      tcnt <= tcnt + 2'd1;
      tick <= (tcnt == 2'd3);
   end

   serial_rx_deser dut (
      .clk(clk), .rst_n(rst_n), .rx_tick(tick), .rx_line(rx),
      .div_sel(div_sel), .word_sel(word_sel), .carrier_lost(carrier_lost),
      .rd_ack(rd_ack), .rx_data(rx_data), .rx_full(rx_full),
      .frame_err(frame_err), .parity_err(parity_err), .overrun(overrun)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      int k = 0;
      while (k < n) begin
         @(posedge clk);
         if (tick) k++;
      end
   endtask

   function automatic logic [1:0] div_code(input int div);
      return (div == 1) ? 2'b00 : (div == 16) ? 2'b01 : 2'b10;
   endfunction

   task automatic send_frame(input logic [7:0] d, input logic [2:0] ws, input int div,
                             input bit bad_par, input bit bad_stop);
      int   nb;
      logic p;
      nb = ws[2] ? 8 : 7;
      p  = ^(ws[2] ? d : {1'b0, d[6:0]}) ^ ws[0];
      if (bad_par) p = ~p;
      wait_ticks(1);
      rx <= 1'b0;
      wait_ticks(div);
      for (int i = 0; i < nb; i++) begin
         rx <= d[i];
         wait_ticks(div);
      end
      if (!ws[2] || ws[1]) begin
         rx <= p;
         wait_ticks(div);
      end
      rx <= !bad_stop;
      wait_ticks(div);
      rx <= 1'b1;
      wait_ticks(2 * div + 2);
      @(negedge clk);
   endtask

   task automatic ack();
      @(negedge clk) rd_ack = 1'b1;
      @(negedge clk) rd_ack = 1'b0;
      @(negedge clk);
   endtask

   task automatic expect_char(input string req, input logic [7:0] d, input logic [2:0] ws,
                              input bit fe, input bit pe);
      check({req, " data"}, rx_data, ws[2] ? d : {1'b0, d[6:0]});
      check({req, " full"}, rx_full, 1'b1);
      check({req, " fe"}, frame_err, fe);
      check({req, " pe"}, parity_err, pe);
      check({req, " ovr"}, overrun, 1'b0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
      int divs [2] = '{1, 16};
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 full", rx_full, 1'b0);
      check("R1 ovr", overrun, 1'b0);
      check("R1 fe", frame_err, 1'b0);
      check("R1 pe", parity_err, 1'b0);
      check("R1 data", rx_data, 8'h00);

      // R2 R3 R4 R7: sweep word formats and two divide ratios
      for (int di = 0; di < 2; di++) begin
         for (int ws = 0; ws < 8; ws++) begin
            for (int pi = 0; pi < 4; pi++) begin
               div_sel  = div_code(divs[di]);
               word_sel = 3'(ws);
               send_frame(pats[pi], 3'(ws), divs[di], 1'b0, 1'b0);
               expect_char("R2", pats[pi], 3'(ws), 1'b0, 1'b0);
               if (ws < 4) check("R3 msb", rx_data[7], 1'b0);
               ack();
               check("R9 ack", rx_full, 1'b0);
            end
         end
      end

      // R4 divide by 64
      div_sel = 2'b10;
      word_sel = 3'b101;
      send_frame(8'h96, 3'b101, 64, 1'b0, 1'b0);
      expect_char("R4 div64", 8'h96, 3'b101, 1'b0, 1'b0);
      ack();
      word_sel = 3'b011;
      send_frame(8'h5A, 3'b011, 64, 1'b0, 1'b0);
      expect_char("R4 div64 7O1", 8'h5A, 3'b011, 1'b0, 1'b0);
      ack();

      // R6 parity errors at ratio 16
      div_sel = 2'b01;
      for (int ws = 0; ws < 8; ws++) begin
         if (ws == 4 || ws == 5) continue;
         word_sel = 3'(ws);
         send_frame(8'h4D, 3'(ws), 16, 1'b1, 1'b0);
         expect_char("R6", 8'h4D, 3'(ws), 1'b0, 1'b1);
         ack();
      end

      // R8 framing error, then a clean frame clears it
      word_sel = 3'b101;
      send_frame(8'hC3, 3'b101, 16, 1'b0, 1'b1);
      expect_char("R8 bad stop", 8'hC3, 3'b101, 1'b1, 1'b0);
      ack();
      send_frame(8'h21, 3'b101, 16, 1'b0, 1'b0);
      expect_char("R8 good stop", 8'h21, 3'b101, 1'b0, 1'b0);
      ack();

      // R10 overrun keeps the earlier character and its flags
      send_frame(8'h11, 3'b101, 16, 1'b0, 1'b0);
      send_frame(8'hEE, 3'b101, 16, 1'b0, 1'b1);
      check("R10 ovr", overrun, 1'b1);
      check("R10 full", rx_full, 1'b1);
      check("R10 data", rx_data, 8'h11);
      check("R10 fe", frame_err, 1'b0);
      ack();
      check("R9 ovr clr", overrun, 1'b0);
      check("R9 full clr", rx_full, 1'b0);
      // R12 reception continues after overrun
      send_frame(8'h7B, 3'b101, 16, 1'b0, 1'b0);
      expect_char("R12", 8'h7B, 3'b101, 1'b0, 1'b0);

      // R11 carrier loss masks full indication
      carrier_lost = 1'b1;
      @(negedge clk);
      check("R11 masked", rx_full, 1'b0);
      check("R11 data kept", rx_data, 8'h7B);
      carrier_lost = 1'b0;
      @(negedge clk);
      check("R11 restored", rx_full, 1'b1);
      ack();

      // R5 glitch shorter than half a bit is discarded
      wait_ticks(1);
      rx <= 1'b0;
      wait_ticks(3);
      rx <= 1'b1;
      wait_ticks(40);
      @(negedge clk);
      check("R5 glitch", rx_full, 1'b0);
      send_frame(8'hB4, 3'b101, 16, 1'b0, 1'b0);
      expect_char("R5 after glitch", 8'hB4, 3'b101, 1'b0, 1'b0);
      ack();

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule